// File: doc/BRIEF.md
# Load address unit

This unit takes one 32-bit word-load instruction at a time from a fixed-length instruction stream. It decodes the addressing form and forms the effective address from a base register or from the program counter. It then issues a single word read to memory. When the read data comes back, it commits the destination write, the base-register update and any jump of the program counter together. Encodings that are not word loads are refused, and so is an instruction whose condition check has already failed. Neither leaves any trace.

The register file is read combinationally. The unit presents the base and offset register indexes taken from the instruction it is being offered. It samples the read data, the carry input and the condition status in the cycle it accepts the instruction. Only one load is in flight. The unit accepts no new instruction until the memory response has been committed.

Top module: `load_agu`

## Requirements
- R1: Immediate form (bits [27:25]=010, bit 22=0, bit 20=1): the offset is the unsigned value in bits [11:0]. It is added to the base when bit 23 is 1 and subtracted modulo 2^32 when bit 23 is 0.
- R2: With bit 24 set, the read address is base plus or minus offset. If bit 21 is also set, that same address is written to the base register named by bits [19:16].
- R3: With bit 24 clear and bit 21 clear, the read address is the unmodified base, and base plus or minus offset is always written back to the base register.
- R4: In the immediate form with bits [19:16]=1111, the base is the instruction address plus 8, rounded down to a multiple of 4. Such a load never writes a base register.
- R5: Register form (bits [27:25]=011, bit 4=0, bit 22=0, bit 20=1): the offset is register bits [3:0], shifted by the amount in bits [11:7] with the kind in bits [6:5]. The kinds are 00 left, 01 logical right, 10 arithmetic right and 11 rotate right. An amount of 0 means 32 for both right shifts. For the rotate it means a one-bit rotate through carry_in.
- R6: A decoded load whose cond_pass is 0 at acceptance is consumed without a memory request and without any register or program-counter write.
- R7: When the destination field (bits [15:12]) is 15, the loaded word drives pc_target with pc_we only if the read address bits [1:0] are 00. Otherwise unpred pulses and neither pc_we nor rd_we is raised. A destination below 15 gets rd_we with the loaded word.
- R8: mem_req_valid holds with an unchanged address until mem_req_ready. All commit outputs are raised only in the cycle mem_rsp_valid returns after that request.
- R9: When the base register equals the destination register, only the loaded word is written and the base update is dropped.
- R10: The following are not handled: bit 24 clear with bit 21 set; the register form with base field 1111; and any encoding matching neither form. For these, unhandled is raised combinationally while offered, no request is made and nothing is written.
- R11: insn_ready is high only when no load is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction offered |
| insn_ready | output | 1 | Unit idle, offer accepted this cycle |
| insn | input | 32 | Instruction word |
| insn_addr | input | 32 | Address of the instruction |
| cond_pass | input | 1 | Condition check result for the offered instruction |
| carry_in | input | 1 | Carry used by the one-bit rotate offset |
| base_ridx | output | 4 | Base register read index |
| base_rdata | input | 32 | Base register value |
| offs_ridx | output | 4 | Offset register read index |
| offs_rdata | input | 32 | Offset register value |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| rd_we | output | 1 | Destination register write |
| rd_idx | output | 4 | Destination register index |
| rd_data | output | 32 | Destination data |
| wb_we | output | 1 | Base register update |
| wb_idx | output | 4 | Base register index |
| wb_data | output | 32 | Updated base value |
| pc_we | output | 1 | Program counter load |
| pc_target | output | 32 | New program counter value |
| unpred | output | 1 | Misaligned load into the program counter |
| unhandled | output | 1 | Offered encoding is not a handled load |

## Verification
The destination write and the base update land in the same response cycle. The bench provokes this with random pre-index writeback and post-index loads. It also forces the base register to equal the destination in both modes, where the loaded word must win and wb_we must stay low. For every such commit the bench compares rd_data against the response word and wb_data against its own base-plus-or-minus-offset. The program-counter load with an aligned or a misaligned address is also combined with post-index writeback, to show that the base update survives an unpred pulse.

// File: rtl/load_agu_pkg.sv
package load_agu_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_WAIT = 2'b10
  } agu_state_e;

  typedef struct packed {
    logic        is_load;
    logic        is_literal;
    logic        reg_form;
    logic        pre_index;
    logic        add;
    logic        writeback;
    logic [3:0]  rn;
    logic [3:0]  rt;
    logic [3:0]  rm;
    shift_kind_e sh;
    logic [4:0]  amt;
    logic [11:0] imm;
  } agu_op_t;

  // Offset shifter: zero amount is special for the right shifts and the rotate.
  function automatic logic [31:0] apply_shift(input logic [31:0] v,
                                              input shift_kind_e k,
                                              input logic [4:0] amt,
                                              input logic cin);
    logic [31:0] r;
    case (k)
      SH_LSL: r = v << amt;
      SH_LSR: r = (amt == 5'd0) ? 32'd0 : (v >> amt);
      SH_ASR: r = (amt == 5'd0) ? {32{v[31]}} : 32'($signed(v) >>> amt);
      default: r = (amt == 5'd0) ? {cin, v[31:1]}
                                 : ((v >> amt) | (v << (6'd32 - {1'b0, amt})));
    endcase
    return r;
  endfunction

  function automatic logic [31:0] add_or_sub(input logic [31:0] b,
                                             input logic [31:0] o,
                                             input logic up);
    return up ? (b + o) : (b - o);
  endfunction

endpackage

// File: rtl/load_agu_decode.sv
module load_agu_decode
  import load_agu_pkg::*;
(
  input  logic [31:0] insn,
  output agu_op_t     op
);
  logic imm_pat, reg_pat, unpriv_combo, reg_pc_base, base_is_pc;
  logic unused_cond;

  assign unused_cond  = ^insn[31:28];
  assign base_is_pc   = (insn[19:16] == 4'hF);
  assign imm_pat      = (insn[27:25] == 3'b010) && !insn[22] && insn[20];
  assign reg_pat      = (insn[27:25] == 3'b011) && !insn[4] && !insn[22] && insn[20];
  assign unpriv_combo = !insn[24] && insn[21];
  assign reg_pc_base  = reg_pat && base_is_pc;

  always_comb begin
    op            = '0;
    op.is_load    = (imm_pat || reg_pat) && !unpriv_combo && !reg_pc_base;
    op.is_literal = imm_pat && base_is_pc;
    op.reg_form   = reg_pat;
    op.pre_index  = insn[24];
    op.add        = insn[23];
    op.writeback  = !(imm_pat && base_is_pc) && (!insn[24] || insn[21]);
    op.rn         = insn[19:16];
    op.rt         = insn[15:12];
    op.rm         = insn[3:0];
    op.sh         = shift_kind_e'(insn[6:5]);
    op.amt        = insn[11:7];
    op.imm        = insn[11:0];
  end
endmodule

// File: rtl/load_agu_addr.sv
module load_agu_addr
  import load_agu_pkg::*;
#(
  parameter int unsigned PC_AHEAD   = 8,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  agu_op_t     op,
  input  logic [31:0] insn_addr,
  input  logic [31:0] base_rdata,
  input  logic [31:0] offs_rdata,
  input  logic        carry_in,
  output logic [31:0] access_addr,
  output logic [31:0] wb_value
);
  logic [31:0] pc_now, pc_base, base, offset, eff;
  logic        unused_addr_fields;

  assign unused_addr_fields = ^{op.is_load, op.writeback, op.rn, op.rt, op.rm};
  assign pc_now  = insn_addr + 32'(PC_AHEAD);
  assign pc_base = {pc_now[31:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  assign base    = op.is_literal ? pc_base : base_rdata;
  assign offset  = op.reg_form ? apply_shift(offs_rdata, op.sh, op.amt, carry_in)
                               : {20'd0, op.imm};
  assign eff         = add_or_sub(base, offset, op.add);
  assign access_addr = op.pre_index ? eff : base;
  assign wb_value    = eff;
endmodule

// File: rtl/load_agu_seq.sv
module load_agu_seq
  import load_agu_pkg::*;
#(
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic        is_load,
  input  logic        cond_pass,
  input  logic        writeback,
  input  logic [3:0]  rn,
  input  logic [3:0]  rt,
  input  logic [31:0] access_addr,
  input  logic [31:0] wb_value,
  output logic        insn_ready,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        rd_we,
  output logic [3:0]  rd_idx,
  output logic [31:0] rd_data,
  output logic        wb_we,
  output logic [3:0]  wb_idx,
  output logic [31:0] wb_data,
  output logic        pc_we,
  output logic [31:0] pc_target,
  output logic        unpred,
  output logic        accept_fire,
  output logic        commit_fire
);
  agu_state_e  state;
  logic [31:0] q_addr, q_wb_val;
  logic [3:0]  q_rn, q_rt;
  logic        q_wb;
  logic        dest_pc, aligned;

  assign insn_ready  = (state == ST_IDLE);
  assign accept_fire = insn_ready && insn_valid && is_load && cond_pass;
  assign commit_fire = (state == ST_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      q_addr   <= '0;
      q_wb_val <= '0;
      q_rn     <= '0;
      q_rt     <= '0;
      q_wb     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept_fire) begin
          state    <= ST_REQ;
          q_addr   <= access_addr;
          q_wb_val <= wb_value;
          q_rn     <= rn;
          q_rt     <= rt;
          q_wb     <= writeback;
        end
        ST_REQ:  if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = q_addr;

  assign dest_pc = (q_rt == 4'hF);
  assign aligned = (q_addr[ALIGN_BITS-1:0] == '0);

  assign rd_we     = commit_fire && !dest_pc;
  assign rd_idx    = q_rt;
  assign rd_data   = mem_rsp_data;
  assign pc_we     = commit_fire && dest_pc && aligned;
  assign pc_target = mem_rsp_data;
  assign unpred    = commit_fire && dest_pc && !aligned;
  assign wb_we     = commit_fire && q_wb && (q_rn != q_rt);
  assign wb_idx    = q_rn;
  assign wb_data   = q_wb_val;
endmodule

// File: rtl/load_agu.sv
module load_agu
  import load_agu_pkg::*;
#(
  parameter int unsigned PC_AHEAD   = 8,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  output logic        insn_ready,
  input  logic [31:0] insn,
  input  logic [31:0] insn_addr,
  input  logic        cond_pass,
  input  logic        carry_in,
  output logic [3:0]  base_ridx,
  input  logic [31:0] base_rdata,
  output logic [3:0]  offs_ridx,
  input  logic [31:0] offs_rdata,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        rd_we,
  output logic [3:0]  rd_idx,
  output logic [31:0] rd_data,
  output logic        wb_we,
  output logic [3:0]  wb_idx,
  output logic [31:0] wb_data,
  output logic        pc_we,
  output logic [31:0] pc_target,
  output logic        unpred,
  output logic        unhandled
);
  localparam int unsigned ALIGN_BITS = $clog2(WORD_BYTES);

  agu_op_t     op;
  logic [31:0] access_addr, wb_value;
  logic        accept_fire, commit_fire;

  load_agu_decode u_dec (.insn(insn), .op(op));

  load_agu_addr #(.PC_AHEAD(PC_AHEAD), .ALIGN_BITS(ALIGN_BITS)) u_addr (
    .op(op), .insn_addr(insn_addr), .base_rdata(base_rdata),
    .offs_rdata(offs_rdata), .carry_in(carry_in),
    .access_addr(access_addr), .wb_value(wb_value)
  );

  load_agu_seq #(.ALIGN_BITS(ALIGN_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .is_load(op.is_load),
    .cond_pass(cond_pass), .writeback(op.writeback), .rn(op.rn), .rt(op.rt),
    .access_addr(access_addr), .wb_value(wb_value), .insn_ready(insn_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rd_we(rd_we), .rd_idx(rd_idx),
    .rd_data(rd_data), .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data),
    .pc_we(pc_we), .pc_target(pc_target), .unpred(unpred),
    .accept_fire(accept_fire), .commit_fire(commit_fire)
  );

  assign base_ridx = op.rn;
  assign offs_ridx = op.rm;
  assign unhandled = insn_valid && insn_ready && !op.is_load;
endmodule

// File: rtl/load_agu_chk.sv
module load_agu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        rd_we,
  input logic [3:0]  rd_idx,
  input logic        wb_we,
  input logic [3:0]  wb_idx,
  input logic        pc_we,
  input logic        unpred,
  input logic        unhandled,
  input logic        accept_fire,
  input logic        commit_fire
);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_commit_on_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we || wb_we || pc_we || unpred) |-> mem_rsp_valid && commit_fire && !mem_req_valid);

  p_pc_or_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_we && unpred));

  p_rd_not_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> rd_idx != 4'hF);

  p_dest_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we && wb_we |-> wb_idx != rd_idx);

  p_unhandled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unhandled |=> !mem_req_valid);

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !insn_ready);

  p_accept_requests_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire |=> mem_req_valid);
endmodule

bind load_agu load_agu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .insn_ready(insn_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .rd_we(rd_we), .rd_idx(rd_idx), .wb_we(wb_we), .wb_idx(wb_idx),
  .pc_we(pc_we), .unpred(unpred), .unhandled(unhandled),
  .accept_fire(accept_fire), .commit_fire(commit_fire)
);

// File: tb/tb_load_agu.sv
`timescale 1ns/1ps
module tb_load_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0, cond_pass = 1'b0, carry_in = 1'b0;
  logic [31:0] insn = '0, insn_addr = '0;
  logic        insn_ready;
  logic [3:0]  base_ridx, offs_ridx;
  logic [31:0] base_rdata, offs_rdata;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rd_we, wb_we, pc_we, unpred, unhandled;
  logic [3:0]  rd_idx, wb_idx;
  logic [31:0] rd_data, wb_data, pc_target;

  logic [31:0] regs [16];
  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  assign base_rdata = regs[base_ridx];
  assign offs_rdata = regs[offs_ridx];

  load_agu dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  function automatic logic [31:0] ref_shift(input logic [31:0] v, input logic [1:0] t,
                                            input logic [4:0] a, input logic c);
    logic [63:0] w;
    int n;
    n = (a == 0 && (t == 2'd1 || t == 2'd2)) ? 32 : int'(a);
    case (t)
      2'd0: w = {32'd0, v} << n;
      2'd1: w = {32'd0, v} >> n;
      2'd2: w = {{32{v[31]}}, v} >> n;
      default: w = (a == 0) ? {32'd0, c, v[31:1]} : ({v, v} >> n);
    endcase
    return w[31:0];
  endfunction

  function automatic logic [31:0] mk_imm(input logic p, input logic u, input logic w,
                                         input logic [3:0] rn, input logic [3:0] rt,
                                         input logic [11:0] imm);
    return {4'hE, 3'b010, p, u, 1'b0, w, 1'b1, rn, rt, imm};
  endfunction

  function automatic logic [31:0] mk_reg(input logic p, input logic u, input logic w,
                                         input logic [3:0] rn, input logic [3:0] rt,
                                         input logic [4:0] amt, input logic [1:0] t,
                                         input logic [3:0] rm);
    return {4'hE, 3'b011, p, u, 1'b0, w, 1'b1, rn, rt, amt, t, 1'b0, rm};
  endfunction

  task automatic run_vec(input logic [31:0] ins, input logic [31:0] pc, input logic cp,
                         input logic cin, input logic [31:0] rdat,
                         input int req_dly, input int rsp_dly);
    logic p, u, w, is_i, is_r, legal, wb_exp;
    logic [3:0] rn, rt;
    logic [31:0] base, off, ea, acc, pcb;
    p = ins[24]; u = ins[23]; w = ins[21];
    rn = ins[19:16]; rt = ins[15:12];
    is_i = ins[27:25] == 3'b010 && !ins[22] && ins[20];
    is_r = ins[27:25] == 3'b011 && !ins[4] && !ins[22] && ins[20];
    legal = (is_i || is_r) && !(!p && w) && !(is_r && rn == 4'hF);
    pcb = pc + 32'd8;
    pcb[1:0] = 2'b00;
    base = (rn == 4'hF) ? pcb : regs[rn];
    off = is_i ? {20'd0, ins[11:0]} : ref_shift(regs[ins[3:0]], ins[6:5], ins[11:7], cin);
    ea = u ? base + off : base - off;
    acc = p ? ea : base;
    wb_exp = (rn != 4'hF) && (!p || w) && (rn != rt);

    @(negedge clk);
    insn = ins; insn_addr = pc; cond_pass = cp; carry_in = cin; insn_valid = 1'b1;
    #1;
    chk("R11 ready when idle", {31'd0, insn_ready}, 32'd1);
    chk("R10 unhandled flag", {31'd0, unhandled}, {31'd0, !legal});
    @(negedge clk);
    insn_valid = 1'b0;
    #1;
    if (!legal || !cp) begin
      for (int k = 0; k < 3; k++) begin
        chk(legal ? "R6 no request" : "R10 no request", {31'd0, mem_req_valid}, 32'd0);
        chk(legal ? "R6 no writes" : "R10 no writes",
            {28'd0, rd_we, wb_we, pc_we, unpred}, 32'd0);
        @(negedge clk);
        #1;
      end
      return;
    end
    chk("R8 request raised", {31'd0, mem_req_valid}, 32'd1);
    chk("R11 busy", {31'd0, insn_ready}, 32'd0);
    chk("R1 R2 R3 R4 R5 address", mem_req_addr, acc);
    for (int k = 0; k < req_dly; k++) begin
      @(negedge clk);
      #1;
      chk("R8 request held", {31'd0, mem_req_valid}, 32'd1);
      chk("R8 address held", mem_req_addr, acc);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    #1;
    for (int k = 0; k < rsp_dly; k++) begin
      chk("R8 no early commit", {27'd0, mem_req_valid, rd_we, wb_we, pc_we, unpred}, 32'd0);
      @(negedge clk);
      #1;
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = rdat;
    #1;
    if (rt == 4'hF) begin
      chk("R7 pc load", {31'd0, pc_we}, {31'd0, acc[1:0] == 2'b00});
      chk("R7 unpred", {31'd0, unpred}, {31'd0, acc[1:0] != 2'b00});
      chk("R7 no rd write", {31'd0, rd_we}, 32'd0);
      if (acc[1:0] == 2'b00) chk("R7 pc target", pc_target, rdat);
    end else begin
      chk("R7 rd write", {31'd0, rd_we}, 32'd1);
      chk("R7 rd index", {28'd0, rd_idx}, {28'd0, rt});
      chk("R9 rd data", rd_data, rdat);
      chk("R7 no pc", {30'd0, pc_we, unpred}, 32'd0);
    end
    chk("R2 R3 R4 R9 base update", {31'd0, wb_we}, {31'd0, wb_exp});
    if (wb_exp) begin
      chk("R2 R3 wb index", {28'd0, wb_idx}, {28'd0, rn});
      chk("R2 R3 wb value", wb_data, ea);
    end
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    #1;
    chk("R11 idle after commit", {31'd0, insn_ready}, 32'd1);
    chk("R8 quiet after commit", {28'd0, rd_we, wb_we, pc_we, unpred}, 32'd0);
  endtask

  task automatic rand_regs();
    for (int i = 0; i < 16; i++) regs[i] = $urandom;
  endtask

  initial begin
    logic [31:0] ins;
    void'($urandom(32'h1D0C5EED));
    rand_regs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11 reset ready", {31'd0, insn_ready}, 32'd1);
    chk("R8 reset quiet", {27'd0, mem_req_valid, rd_we, wb_we, pc_we, unpred}, 32'd0);

    // Directed corners
    regs[2] = 32'h0000_1000;
    run_vec(mk_imm(1, 1, 0, 4'd2, 4'd15, 12'd4), 32'h100, 1, 0, 32'hCAFE_0000, 0, 0);  // R7 aligned
    run_vec(mk_imm(1, 1, 0, 4'd2, 4'd15, 12'd5), 32'h100, 1, 0, 32'h1234_5678, 1, 1);  // R7 misaligned
    run_vec(mk_imm(0, 1, 0, 4'd2, 4'd15, 12'd7), 32'h100, 1, 0, 32'h1, 0, 0);          // R7 with R3 base update
    run_vec(mk_imm(1, 0, 1, 4'd2, 4'd2, 12'h10), 32'h100, 1, 0, 32'hABCD, 0, 0);      // R9 pre-index
    run_vec(mk_imm(0, 1, 0, 4'd5, 4'd5, 12'h10), 32'h100, 1, 0, 32'h55, 2, 0);        // R9 post-index
    regs[3] = 32'd4;
    run_vec(mk_imm(1, 0, 1, 4'd3, 4'd1, 12'hFFF), 32'h100, 1, 0, 32'h9, 0, 0);       // R1 wrap below zero
    run_vec(mk_imm(1, 1, 1, 4'd15, 4'd4, 12'h3), 32'h0000_2002, 1, 0, 32'h7, 0, 0);   // R4 literal, no wb
    run_vec(mk_imm(1, 0, 0, 4'd15, 4'd4, 12'h20), 32'h0000_3001, 1, 0, 32'h8, 0, 0);  // R4 subtract
    regs[6] = 32'h8000_0001;
    run_vec(mk_reg(1, 1, 0, 4'd2, 4'd1, 5'd0, 2'd3, 4'd6), 32'h0, 1, 1, 32'h1, 0, 0); // R5 rotate carry 1
    run_vec(mk_reg(1, 1, 0, 4'd2, 4'd1, 5'd0, 2'd3, 4'd6), 32'h0, 1, 0, 32'h1, 0, 0); // R5 rotate carry 0
    run_vec(mk_reg(1, 1, 0, 4'd2, 4'd1, 5'd0, 2'd2, 4'd6), 32'h0, 1, 0, 32'h1, 0, 0); // R5 arith 32
    run_vec(mk_reg(1, 1, 0, 4'd2, 4'd1, 5'd0, 2'd1, 4'd6), 32'h0, 1, 0, 32'h1, 0, 0); // R5 logical 32
    run_vec(mk_reg(0, 0, 0, 4'd2, 4'd1, 5'd4, 2'd0, 4'd6), 32'h0, 1, 0, 32'h1, 0, 0); // R5 left, R3
    run_vec(mk_imm(1, 1, 0, 4'd2, 4'd1, 12'd8), 32'h0, 0, 0, 32'h1, 0, 0);             // R6 cond fail
    run_vec(mk_imm(0, 1, 1, 4'd2, 4'd1, 12'd8), 32'h0, 1, 0, 32'h1, 0, 0);             // R10 unpriv combo
    run_vec(mk_reg(1, 1, 0, 4'd15, 4'd1, 5'd1, 2'd0, 4'd3), 32'h0, 1, 0, 32'h1, 0, 0); // R10 pc base reg form
    run_vec(mk_imm(1, 1, 0, 4'd2, 4'd1, 12'd8) | 32'h0040_0000, 32'h0, 1, 0, 32'h1, 0, 0); // R10 byte
    run_vec(mk_reg(1, 1, 0, 4'd2, 4'd1, 5'd1, 2'd0, 4'd3) | 32'h10, 32'h0, 1, 0, 32'h1, 0, 0); // R10 bit4

    // Constrained random
    for (int v = 0; v < 400; v++) begin
      logic p, w;
      logic [3:0] rn;
      int form;
      rand_regs();
      form = $urandom_range(0, 9);
      p = $urandom_range(0, 1);
      w = p ? 1'($urandom_range(0, 1)) : 1'b0;
      rn = 4'($urandom);
      if (form < 5) begin
        ins = mk_imm(p, 1'($urandom), w, rn, 4'($urandom), 12'($urandom));
      end else if (form < 9) begin
        if (rn == 4'hF) rn = 4'd0;
        ins = mk_reg(p, 1'($urandom), w, rn, 4'($urandom), 5'($urandom),
                     2'($urandom), 4'($urandom));
      end else begin
        ins = $urandom;
      end
      if ($urandom_range(0, 3) == 0) ins[15:12] = ins[19:16];
      run_vec(ins, $urandom, ($urandom_range(0, 7) != 0), 1'($urandom), $urandom,
              $urandom_range(0, 3), $urandom_range(0, 3));
    end
    finish_run();
  end
endmodule